// File: doc/BRIEF.md
# Presence-Tagged Synchronizing Word Memory

This block is a small word-addressed memory in which each word has one presence bit that says whether the word holds produced data. Producers write words, and each write marks its word as present. Consumers issue tagged reads. A read of a present word returns its data one cycle after the read is accepted. A read of an absent word does not stall the request channel. The read is parked in a small table of waiting reads, and it completes with the new value once some producer writes that word. A clear request marks a word absent again so that the location can be reused in a later phase of a computation.

Requests arrive on one valid/ready channel that carries an operation code, a word address, write data and a requester tag. Responses leave on a channel with a valid strobe, the tag of the read and the data. Because parked reads complete whenever their word is written, responses can return in a different order from the one in which the reads were issued, and the tag tells the reads apart. A one-cycle warning pulse reports a write to a word that was already present.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset, every word is absent, `rsp_valid` and `dbl_wr` are low, and `req_ready` is high. A read issued right after reset gets no response until that word is written.
- R2: Operation codes on `req_op` are 2'b00 read, 2'b01 write, 2'b10 clear, and 2'b11 does nothing. A write stores `req_data` and marks the word present. A read of a present word is answered in the cycle after acceptance, with `rsp_valid` high, the read's tag and the stored data.
- R3: A read of an absent word produces no response while the word stays absent. After that word is written, the read is answered with the written data.
- R4: A single write releases every read waiting on its address. Released reads leave the response channel one per cycle, starting in the cycle after the write, lowest table slot first. Slots are filled lowest free slot first, so tags can return out of order relative to issue.
- R5: When a present-word read is accepted in a cycle where released reads are queued, the present-word response goes out first and the queued responses follow in the cycles after it.
- R6: A clear marks its word absent, so a later read of it waits for the next write. A clear does not affect other words, and it does not cancel reads that are already waiting.
- R7: A write to a word that is already present overwrites the word and pulses `dbl_wr` high for exactly the cycle after acceptance. A write to an absent word leaves `dbl_wr` low.
- R8: While all PEND table slots hold waiting or released reads, `req_ready` is low when `req_op` is read and high for write and clear. A write can therefore still release the table.
- R9: A waiting read does not block later requests. Reads of other present words are still answered with one-cycle latency while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 clear, 11 none |
| req_addr | input | AW | Word address |
| req_data | input | DW | Write data |
| req_tag | input | TW | Requester tag for reads |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_tag | output | TW | Tag of the read being answered |
| rsp_data | output | DW | Read data |
| dbl_wr | output | 1 | Pulse: write hit a word that was already present |

## Verification
If a presence bit is wrong, the fault shows up one cycle after the next read of that word. Either a response appears that should have waited, or a read never completes. If a table slot has the wrong state or address, a write releases the wrong tags, or the right tags with the wrong data or in the wrong cycle. The bench therefore checks the exact response cycle of each tag. A slot that leaks shows as `req_ready` staying low for reads after a write should have drained the table.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_CLR = 2'b10,
        OP_NOP = 2'b11
    } fe_op_e;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'b00,
        SLOT_WAIT = 2'b01,
        SLOT_DONE = 2'b10
    } slot_st_e;

    localparam int DEF_AW   = 4;
    localparam int DEF_DW   = 16;
    localparam int DEF_TW   = 4;
    localparam int DEF_PEND = 4;

endpackage

// File: rtl/fe_word_store.sv
module fe_word_store #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int WORDS = 1 << AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             clr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rfull,
    output logic [WORDS-1:0] full_vec
);

    logic [DW-1:0]    mem_q [WORDS];
    logic [WORDS-1:0] full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            if (wr_en) begin
                mem_q[addr]  <= wdata;
                full_q[addr] <= 1'b1;
            end else if (clr_en) begin
                full_q[addr] <= 1'b0;
            end
        end
    end

    assign rdata    = mem_q[addr];
    assign rfull    = full_q[addr];
    assign full_vec = full_q;

endmodule

// File: rtl/fe_pend_table.sv
module fe_pend_table
    import fe_pkg::*;
#(
    parameter int PEND = 4,
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int TW   = 4,
    localparam int IW  = (PEND > 1) ? $clog2(PEND) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [AW-1:0]    alloc_addr,
    input  logic [TW-1:0]    alloc_tag,
    input  logic             wake_en,
    input  logic [AW-1:0]    wake_addr,
    input  logic [DW-1:0]    wake_data,
    input  logic             drain_en,
    output logic             tbl_full,
    output logic             done_any,
    output logic [TW-1:0]    drain_tag,
    output logic [DW-1:0]    drain_data,
    output logic [PEND-1:0]  wait_vec,
    output logic [PEND-1:0]  done_vec,
    output logic [PEND*AW-1:0] ent_addr
);

    typedef struct packed {
        slot_st_e      st;
        logic [AW-1:0] addr;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } slot_t;

    slot_t         slot_q [PEND];
    logic [IW-1:0] alloc_idx;
    logic [IW-1:0] drain_idx;
    logic [PEND-1:0] free_vec;

    always_comb begin
        alloc_idx = '0;
        drain_idx = '0;
        for (int i = PEND - 1; i >= 0; i--) begin
            if (free_vec[i]) alloc_idx = IW'(i);
            if (done_vec[i]) drain_idx = IW'(i);
        end
    end

    generate
        for (genvar g = 0; g < PEND; g++) begin : g_slot
            assign free_vec[g] = (slot_q[g].st == SLOT_FREE);
            assign wait_vec[g] = (slot_q[g].st == SLOT_WAIT);
            assign done_vec[g] = (slot_q[g].st == SLOT_DONE);
            assign ent_addr[g*AW +: AW] = slot_q[g].addr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[g] <= '{st: SLOT_FREE, addr: '0, tag: '0, data: '0};
                end else begin
                    if (drain_en && drain_idx == IW'(g) && done_vec[g])
                        slot_q[g].st <= SLOT_FREE;
                    if (wake_en && wait_vec[g] && slot_q[g].addr == wake_addr) begin
                        slot_q[g].st   <= SLOT_DONE;
                        slot_q[g].data <= wake_data;
                    end
                    if (alloc_en && alloc_idx == IW'(g) && free_vec[g]) begin
                        slot_q[g].st   <= SLOT_WAIT;
                        slot_q[g].addr <= alloc_addr;
                        slot_q[g].tag  <= alloc_tag;
                    end
                end
            end
        end
    endgenerate

    assign tbl_full   = ~|free_vec;
    assign done_any   = |done_vec;
    assign drain_tag  = slot_q[drain_idx].tag;
    assign drain_data = slot_q[drain_idx].data;

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
    import fe_pkg::*;
#(
    parameter int AW   = DEF_AW,
    parameter int DW   = DEF_DW,
    parameter int TW   = DEF_TW,
    parameter int PEND = DEF_PEND,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [TW-1:0] req_tag,
    output logic          rsp_valid,
    output logic [TW-1:0] rsp_tag,
    output logic [DW-1:0] rsp_data,
    output logic          dbl_wr
);

    fe_op_e           op;
    logic             acc, rd_hit, rd_miss, wr_acc, clr_acc;
    logic [DW-1:0]    st_rdata;
    logic             st_rfull;
    logic [WORDS-1:0] full_vec;
    logic             tbl_full, done_any, drain_en;
    logic [TW-1:0]    drain_tag;
    logic [DW-1:0]    drain_data;
    logic [PEND-1:0]  wait_vec, done_vec;
    logic [PEND*AW-1:0] ent_addr;

    assign op        = fe_op_e'(req_op);
    assign req_ready = !(op == OP_RD && tbl_full);
    assign acc       = req_valid && req_ready;
    assign rd_hit    = acc && op == OP_RD && st_rfull;
    assign rd_miss   = acc && op == OP_RD && !st_rfull;
    assign wr_acc    = acc && op == OP_WR;
    assign clr_acc   = acc && op == OP_CLR;
    assign drain_en  = done_any && !rd_hit;

    fe_word_store #(.AW(AW), .DW(DW)) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_acc),
        .clr_en   (clr_acc),
        .addr     (req_addr),
        .wdata    (req_data),
        .rdata    (st_rdata),
        .rfull    (st_rfull),
        .full_vec (full_vec)
    );

    fe_pend_table #(.PEND(PEND), .AW(AW), .DW(DW), .TW(TW)) table_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (rd_miss),
        .alloc_addr (req_addr),
        .alloc_tag  (req_tag),
        .wake_en    (wr_acc),
        .wake_addr  (req_addr),
        .wake_data  (req_data),
        .drain_en   (drain_en),
        .tbl_full   (tbl_full),
        .done_any   (done_any),
        .drain_tag  (drain_tag),
        .drain_data (drain_data),
        .wait_vec   (wait_vec),
        .done_vec   (done_vec),
        .ent_addr   (ent_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_tag   <= '0;
            rsp_data  <= '0;
            dbl_wr    <= 1'b0;
        end else begin
            rsp_valid <= rd_hit || drain_en;
            if (rd_hit) begin
                rsp_tag  <= req_tag;
                rsp_data <= st_rdata;
            end else if (drain_en) begin
                rsp_tag  <= drain_tag;
                rsp_data <= drain_data;
            end
            dbl_wr <= wr_acc && st_rfull;
        end
    end

endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
    parameter int AW   = 4,
    parameter int TW   = 4,
    parameter int PEND = 4,
    localparam int WORDS = 1 << AW
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic [AW-1:0]    req_addr,
    input logic [TW-1:0]    req_tag,
    input logic             rsp_valid,
    input logic [TW-1:0]    rsp_tag,
    input logic             dbl_wr,
    input logic [WORDS-1:0] full_vec,
    input logic [PEND-1:0]  wait_vec,
    input logic [PEND-1:0]  done_vec,
    input logic [PEND*AW-1:0] ent_addr
);

    logic            acc;
    logic            hit_now;
    logic [PEND-1:0] wait_on_full;

    assign acc     = req_valid && req_ready;
    assign hit_now = acc && req_op == 2'b00 && full_vec[req_addr];

    always_comb begin
        for (int i = 0; i < PEND; i++)
            wait_on_full[i] = wait_vec[i] && full_vec[ent_addr[i*AW +: AW]];
    end

    // R2
    hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
        hit_now |=> (rsp_valid && rsp_tag == $past(req_tag)));

    // R3
    no_wait_on_full_chk: assert property (@(posedge clk) disable iff (rst)
        wait_on_full == '0);

    // R4
    drain_source_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(hit_now)) |-> $past(|done_vec));

    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 2'b10) |=> !full_vec[$past(req_addr)]);

    // R7
    dbl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dbl_wr |-> $past(acc && req_op == 2'b01 && full_vec[req_addr]));

    // R8
    ready_block_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (req_op == 2'b00 && (&(wait_vec | done_vec))));

endmodule

bind fe_sync_mem fe_sync_mem_chk #(.AW(AW), .TW(TW), .PEND(PEND)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_tag   (req_tag),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .dbl_wr    (dbl_wr),
    .full_vec  (full_vec),
    .wait_vec  (wait_vec),
    .done_vec  (done_vec),
    .ent_addr  (ent_addr)
);

// File: tb/fe_sync_mem_tb.sv
module fe_sync_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4, DW = 16, TW = 4, PEND = 4;
    localparam int NTAG = 1 << TW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b11;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [TW-1:0] req_tag = '0;
    logic          rsp_valid;
    logic [TW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data;
    logic          dbl_wr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int acc_cyc = 0;
    logic acc_dbl = 1'b0;
    logic got [NTAG];
    int   got_data [NTAG];
    int   got_cyc [NTAG];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fe_sync_mem #(.AW(AW), .DW(DW), .TW(TW), .PEND(PEND)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .dbl_wr(dbl_wr)
    );

    always @(negedge clk) begin
        if (rsp_valid) begin
            got[rsp_tag]      = 1'b1;
            got_data[rsp_tag] = int'(rsp_data);
            got_cyc[rsp_tag]  = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < NTAG; i++) begin
            got[i] = 1'b0; got_data[i] = 0; got_cyc[i] = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive at a negedge; returns at the negedge after acceptance
    task automatic send(input logic [1:0] op, input int addr, input int data, input int tag);
        req_valid = 1'b1; req_op = op;
        req_addr = AW'(addr); req_data = DW'(data); req_tag = TW'(tag);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        acc_dbl = dbl_wr;
        req_valid = 1'b0; req_op = 2'b11;
    endtask

    task automatic expect_rsp(input int tag, input int data, input int at, input string req);
        check(got[tag], req, int'(got[tag]), 1);
        check(got_data[tag] == data, req, got_data[tag], data);
        check(got_cyc[tag] == at, req, got_cyc[tag], at);
    endtask

    task automatic expect_none(input int tag, input string req);
        check(!got[tag], req, int'(got[tag]), 0);
    endtask

    task automatic t_reset();
        clear_log();
        check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        check(dbl_wr == 1'b0, "R1 dbl_wr", int'(dbl_wr), 0);
        check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        send(2'b00, 3, 0, 1);
        idle(5);
        expect_none(1, "R1 word absent after reset");
        send(2'b01, 3, 16'h0033, 0);
        idle(3);
        expect_rsp(1, 16'h0033, acc_cyc + 1, "R1 late write releases read");
    endtask

    task automatic t_hit();
        clear_log();
        send(2'b01, 5, 16'hA5A5, 0);
        send(2'b00, 5, 0, 2);
        idle(3);
        expect_rsp(2, 16'hA5A5, acc_cyc, "R2 present read");
    endtask

    task automatic t_pend();
        int wr_c;
        clear_log();
        send(2'b00, 7, 0, 3);
        idle(4);
        expect_none(3, "R3 absent read waits");
        send(2'b01, 9, 16'h0909, 0);
        send(2'b00, 9, 0, 4);
        idle(2);
        expect_rsp(4, 16'h0909, acc_cyc, "R9 other read not blocked");
        expect_none(3, "R3 still waiting");
        send(2'b01, 7, 16'h1234, 0);
        wr_c = acc_cyc;
        idle(3);
        expect_rsp(3, 16'h1234, wr_c + 1, "R3 released with write data");
    endtask

    task automatic t_multi();
        int wr_c;
        clear_log();
        send(2'b00, 10, 0, 5);
        send(2'b00, 11, 0, 6);
        send(2'b00, 10, 0, 7);
        send(2'b01, 11, 16'h0B0B, 0);
        wr_c = acc_cyc;
        idle(3);
        expect_rsp(6, 16'h0B0B, wr_c + 1, "R4 later tag returns first");
        expect_none(5, "R4 other address untouched");
        send(2'b01, 10, 16'h0A0A, 0);
        wr_c = acc_cyc;
        idle(4);
        expect_rsp(5, 16'h0A0A, wr_c + 1, "R4 slot0 drains first");
        expect_rsp(7, 16'h0A0A, wr_c + 2, "R4 slot2 drains next");
    endtask

    task automatic t_prio();
        int wr_c;
        clear_log();
        send(2'b01, 12, 16'h0C0C, 0);
        send(2'b00, 13, 0, 8);
        send(2'b00, 13, 0, 9);
        send(2'b01, 13, 16'h0D0D, 0);
        wr_c = acc_cyc;
        send(2'b00, 12, 0, 10);
        idle(5);
        expect_rsp(10, 16'h0C0C, wr_c + 1, "R5 present read first");
        expect_rsp(8, 16'h0D0D, wr_c + 2, "R5 queued read after");
        expect_rsp(9, 16'h0D0D, wr_c + 3, "R5 second queued read");
    endtask

    task automatic t_clear();
        int wr_c;
        clear_log();
        send(2'b01, 14, 16'h0E0E, 0);
        send(2'b10, 14, 0, 0);
        send(2'b00, 14, 0, 11);
        idle(4);
        expect_none(11, "R6 cleared word waits");
        send(2'b10, 14, 0, 0);
        send(2'b00, 12, 0, 12);
        idle(2);
        expect_rsp(12, 16'h0C0C, acc_cyc, "R6 other word kept");
        send(2'b01, 14, 16'h4E4E, 0);
        wr_c = acc_cyc;
        idle(3);
        expect_rsp(11, 16'h4E4E, wr_c + 1, "R6 wait survives clear");
    endtask

    task automatic t_dbl();
        clear_log();
        send(2'b01, 1, 16'h1111, 0);
        check(acc_dbl == 1'b0, "R7 first write no flag", int'(acc_dbl), 0);
        send(2'b01, 1, 16'h2222, 0);
        check(acc_dbl == 1'b1, "R7 double write flag", int'(acc_dbl), 1);
        idle(1);
        check(dbl_wr == 1'b0, "R7 flag one cycle", int'(dbl_wr), 0);
        send(2'b00, 1, 0, 13);
        idle(2);
        expect_rsp(13, 16'h2222, acc_cyc, "R7 overwrite data");
    endtask

    task automatic t_full();
        int wr_c;
        clear_log();
        for (int t = 0; t < PEND; t++) send(2'b00, 2, 0, t);
        req_op = 2'b00; req_valid = 1'b0;
        #1;
        check(req_ready == 1'b0, "R8 read blocked when full", int'(req_ready), 0);
        req_op = 2'b10;
        #1;
        check(req_ready == 1'b1, "R8 clear accepted when full", int'(req_ready), 1);
        req_op = 2'b01;
        #1;
        check(req_ready == 1'b1, "R8 write accepted when full", int'(req_ready), 1);
        idle(1);
        send(2'b01, 2, 16'h0202, 0);
        wr_c = acc_cyc;
        idle(6);
        for (int t = 0; t < PEND; t++)
            expect_rsp(t, 16'h0202, wr_c + 1 + t, "R8 table drains");
        req_op = 2'b00;
        #1;
        check(req_ready == 1'b1, "R8 ready after drain", int'(req_ready), 1);
        req_op = 2'b11;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hit();
        t_pend();
        t_multi();
        t_prio();
        t_clear();
        t_dbl();
        t_full();
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule